// File: doc/BRIEF.md
# Queued Serial Port Controller

This block wraps an 8N1 serial transmitter and receiver (one start bit, eight data bits sent least significant bit first, one stop bit, no parity) with two byte queues of `DEPTH` entries, 16 by default. Application logic hands bytes to the transmit queue through a push port. A combinational accept flag answers each push in the cycle it is offered. The controller drains the queue onto the serial line one frame at a time. Bytes that arrive whole on the receive line are stored in the receive queue and read back through a pop port.

Before a multi-byte message is pushed, the caller can compare its length against the free transmit space. The fit flag tells whether the whole message would be taken, so a caller that pushes only when the fit flag is high never leaves a partial message queued. Status outputs give the receive fill level, the free transmit space, a busy flag, a sticky framing-error flag and a saturating framing-error counter. Three clear strobes empty the receive queue, empty the transmit queue and reset the error tracking.

Top module: `buffered_uart`

## Requirements
- R1: Each queue holds `DEPTH` (16) bytes. After reset `rx_count` is 0, `tx_free` is `DEPTH`, `busy` is 0, `frame_err` and `frame_err_cnt` are 0, and `tx_out` idles high.
- R2: `push_ok` is high in the same cycle as `push_valid` only when the transmit queue is not full and `clr_tx` is low. A refused byte is never sent.
- R3: `msg_fits` is high exactly when `msg_len` is less than or equal to `tx_free`.
- R4: Frames are 8N1, LSB first, with each bit lasting `CLKS_PER_BIT` clocks and the line idling high. The next byte is taken from the queue only after the previous frame's stop bit has ended. Bytes come out in push order.
- R5: A byte that completes while the receive queue already holds `DEPTH` bytes is discarded, and the stored bytes are left unchanged.
- R6: `pop_data` shows the oldest received byte. `pop_req` removes that byte when the queue is not empty and has no effect when it is empty.
- R7: A frame whose stop bit samples low is not stored. It sets `frame_err`, which stays high until it is cleared, and it increments `frame_err_cnt`, which stops at 2^`ERR_W`-1 instead of wrapping.
- R8: `busy` is high while the transmit queue holds a byte or a frame is being sent.
- R9: `clr_rx` empties the receive queue. `clr_tx` empties the transmit queue, and a frame already on the line still finishes. `clr_err` zeroes the flag and the counter. A clear wins over a push, a stored byte or a framing error in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Serial receive line |
| tx_out | output | 1 | Serial transmit line |
| push_valid | input | 1 | Offer `push_data` to the transmit queue |
| push_data | input | 8 | Byte to transmit |
| push_ok | output | 1 | Offered byte is accepted this cycle |
| msg_len | input | $clog2(DEPTH+1) | Length of a planned message |
| msg_fits | output | 1 | Planned message fits completely |
| pop_req | input | 1 | Remove the oldest received byte |
| pop_data | output | 8 | Oldest received byte |
| clr_rx | input | 1 | Empty the receive queue |
| clr_tx | input | 1 | Empty the transmit queue |
| clr_err | input | 1 | Clear the framing-error flag and counter |
| rx_count | output | $clog2(DEPTH+1) | Received bytes waiting to be read |
| tx_free | output | $clog2(DEPTH+1) | Free transmit queue entries |
| busy | output | 1 | Transmit work pending or in progress |
| frame_err | output | 1 | Sticky framing-error flag |
| frame_err_cnt | output | ERR_W | Saturating framing-error count |

## Verification
Two kinds of same-cycle conflict are tested. In the first, a clear lands on the cycle of a queue event: a push is offered together with `clr_tx` and must be refused with `tx_free` unchanged, and `clr_rx` or `clr_err` is held high across a whole incoming frame, so that the byte completion or the framing-error event falls inside the clear and leaves the queue empty and the counter at zero. In the second, a full receive queue meets an arriving byte: seventeen bytes are looped back while nothing is popped, and the popped contents must be exactly the first sixteen. The bench also fills the transmit queue while the first frame is being launched, and checks that the 18th push is the first one refused.

// File: rtl/buffered_uart.sv
module buffered_uart #(
  parameter int CLKS_PER_BIT = 868,
  parameter int DEPTH = 16,
  parameter int ERR_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  output logic             tx_out,
  input  logic             push_valid,
  input  logic [7:0]       push_data,
  output logic             push_ok,
  input  logic [CW-1:0]    msg_len,
  output logic             msg_fits,
  input  logic             pop_req,
  output logic [7:0]       pop_data,
  input  logic             clr_rx,
  input  logic             clr_tx,
  input  logic             clr_err,
  output logic [CW-1:0]    rx_count,
  output logic [CW-1:0]    tx_free,
  output logic             busy,
  output logic             frame_err,
  output logic [ERR_W-1:0] frame_err_cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [TW-1:0] BIT_END = TW'(CLKS_PER_BIT - 1);
  localparam logic [TW-1:0] HALF_END = TW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} ser_t;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // transmit queue
  logic [7:0]    tq_mem [DEPTH];
  logic [AW-1:0] tq_wr, tq_rd;
  logic [CW-1:0] tq_cnt;
  ser_t          ts;
  logic [TW-1:0] t_tick;
  logic [2:0]    t_bit;
  logic [7:0]    t_sh;
  logic          launch;

  assign push_ok  = push_valid && (tq_cnt != CW'(DEPTH)) && !clr_tx;
  assign launch   = (ts == S_IDLE) && (tq_cnt != '0) && !clr_tx;
  assign tx_free  = CW'(DEPTH) - tq_cnt;
  assign msg_fits = (msg_len <= tx_free);
  assign busy     = (tq_cnt != '0) || (ts != S_IDLE);

  always_ff @(posedge clk) begin
    if (push_ok) tq_mem[tq_wr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_tx) begin
      tq_wr  <= '0;
      tq_rd  <= '0;
      tq_cnt <= '0;
    end else begin
      if (push_ok) tq_wr <= wrap_inc(tq_wr);
      if (launch)  tq_rd <= wrap_inc(tq_rd);
      tq_cnt <= tq_cnt + CW'(push_ok) - CW'(launch);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts     <= S_IDLE;
      t_tick <= '0;
      t_bit  <= '0;
      t_sh   <= '0;
      tx_out <= 1'b1;
    end else begin
      case (ts)
        S_IDLE: if (launch) begin
          ts     <= S_START;
          t_sh   <= tq_mem[tq_rd];
          t_tick <= '0;
          tx_out <= 1'b0;
        end
        S_START: if (t_tick == BIT_END) begin
          ts     <= S_DATA;
          t_tick <= '0;
          t_bit  <= '0;
          tx_out <= t_sh[0];
        end else t_tick <= t_tick + 1'b1;
        S_DATA: if (t_tick == BIT_END) begin
          t_tick <= '0;
          if (t_bit == 3'd7) begin
            ts     <= S_STOP;
            tx_out <= 1'b1;
          end else begin
            t_bit  <= t_bit + 1'b1;
            t_sh   <= t_sh >> 1;
            tx_out <= t_sh[1];
          end
        end else t_tick <= t_tick + 1'b1;
        S_STOP: if (t_tick == BIT_END) begin
          ts     <= S_IDLE;
          t_tick <= '0;
        end else t_tick <= t_tick + 1'b1;
        default: ts <= S_IDLE;
      endcase
    end
  end

  // receiver
  logic [2:0]    r_sync;
  logic          r_line;
  ser_t          rs;
  logic [TW-1:0] r_tick;
  logic [2:0]    r_bit;
  logic [7:0]    r_sh;
  logic          r_done, r_bad;

  assign r_line = r_sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_sync <= 3'b111;
      rs     <= S_IDLE;
      r_tick <= '0;
      r_bit  <= '0;
      r_sh   <= '0;
      r_done <= 1'b0;
      r_bad  <= 1'b0;
    end else begin
      r_sync <= {r_sync[1:0], rx_in};
      r_done <= 1'b0;
      r_bad  <= 1'b0;
      case (rs)
        S_IDLE: if (r_sync[2] && !r_line) begin
          rs     <= S_START;
          r_tick <= '0;
        end
        S_START: if (r_tick == HALF_END) begin
          r_tick <= '0;
          r_bit  <= '0;
          rs     <= r_line ? S_IDLE : S_DATA;
        end else r_tick <= r_tick + 1'b1;
        S_DATA: if (r_tick == BIT_END) begin
          r_tick <= '0;
          r_sh   <= {r_line, r_sh[7:1]};
          r_bit  <= r_bit + 1'b1;
          if (r_bit == 3'd7) rs <= S_STOP;
        end else r_tick <= r_tick + 1'b1;
        S_STOP: if (r_tick == BIT_END) begin
          r_tick <= '0;
          rs     <= S_IDLE;
          r_done <= r_line;
          r_bad  <= !r_line;
        end else r_tick <= r_tick + 1'b1;
        default: rs <= S_IDLE;
      endcase
    end
  end

  // receive queue
  logic [7:0]    rq_mem [DEPTH];
  logic [AW-1:0] rq_wr, rq_rd;
  logic          rq_put, rq_take;

  assign rq_put   = r_done && (rx_count != CW'(DEPTH)) && !clr_rx;
  assign rq_take  = pop_req && (rx_count != '0) && !clr_rx;
  assign pop_data = rq_mem[rq_rd];

  always_ff @(posedge clk) begin
    if (rq_put) rq_mem[rq_wr] <= r_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_rx) begin
      rq_wr    <= '0;
      rq_rd    <= '0;
      rx_count <= '0;
    end else begin
      if (rq_put)  rq_wr <= wrap_inc(rq_wr);
      if (rq_take) rq_rd <= wrap_inc(rq_rd);
      rx_count <= rx_count + CW'(rq_put) - CW'(rq_take);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_err) begin
      frame_err     <= 1'b0;
      frame_err_cnt <= '0;
    end else if (r_bad) begin
      frame_err <= 1'b1;
      if (frame_err_cnt != '1) frame_err_cnt <= frame_err_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/buffered_uart_chk.sv
module buffered_uart_chk #(
  parameter int DEPTH = 16,
  parameter int ERR_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_out,
  input logic             push_ok,
  input logic             clr_rx,
  input logic             clr_tx,
  input logic             clr_err,
  input logic [CW-1:0]    rx_count,
  input logic [CW-1:0]    tx_free,
  input logic             busy,
  input logic             frame_err,
  input logic [ERR_W-1:0] frame_err_cnt
);
  assert_depth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_free <= CW'(DEPTH)));
  assert_refuse_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free == '0) |-> !push_ok);
  assert_idle_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_out);
  assert_idle_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free != CW'(DEPTH)) |-> busy);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !clr_err) |=> frame_err);
  assert_err_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((frame_err_cnt == '1) && !clr_err) |=> (frame_err_cnt == '1));
  assert_clr_tx_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tx |-> !push_ok);
  assert_clr_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rx |=> (rx_count == '0));
  assert_clr_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (!frame_err && (frame_err_cnt == '0)));
endmodule

bind buffered_uart buffered_uart_chk #(.DEPTH(DEPTH), .ERR_W(ERR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_out(tx_out), .push_ok(push_ok),
  .clr_rx(clr_rx), .clr_tx(clr_tx), .clr_err(clr_err),
  .rx_count(rx_count), .tx_free(tx_free), .busy(busy),
  .frame_err(frame_err), .frame_err_cnt(frame_err_cnt)
);

// File: tb/buffered_uart_tb_top.sv
module buffered_uart_tb_top;
  localparam int CPB = 8;
  localparam int DEPTH = 16;
  localparam int ERR_W = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic use_loop = 1'b1, bench_line = 1'b1;
  logic rx_in, tx_out, push_valid = 0, push_ok, msg_fits, pop_req = 0;
  logic clr_rx = 0, clr_tx = 0, clr_err = 0, busy, frame_err;
  logic [7:0] push_data = '0, pop_data;
  logic [CW-1:0] msg_len = '0, rx_count, tx_free;
  logic [ERR_W-1:0] frame_err_cnt;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign rx_in = use_loop ? tx_out : bench_line;

  buffered_uart #(.CLKS_PER_BIT(CPB), .DEPTH(DEPTH), .ERR_W(ERR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tx_out(tx_out),
    .push_valid(push_valid), .push_data(push_data), .push_ok(push_ok),
    .msg_len(msg_len), .msg_fits(msg_fits), .pop_req(pop_req),
    .pop_data(pop_data), .clr_rx(clr_rx), .clr_tx(clr_tx), .clr_err(clr_err),
    .rx_count(rx_count), .tx_free(tx_free), .busy(busy),
    .frame_err(frame_err), .frame_err_cnt(frame_err_cnt));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_count(input int n);
    for (int i = 0; i < 4000 && rx_count != CW'(n); i++) @(negedge clk);
  endtask

  task automatic pop_one(input int exp, input string req);
    @(negedge clk);
    chk(pop_data == 8'(exp), req, pop_data, exp);
    pop_req = 1;
    @(negedge clk);
    pop_req = 0;
  endtask

  task automatic raw_frame(input logic [7:0] d, input logic stop);
    @(negedge clk);
    bench_line = 0;
    repeat (CPB) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      bench_line = d[b];
      repeat (CPB) @(negedge clk);
    end
    bench_line = stop;
    repeat (CPB) @(negedge clk);
    bench_line = 1;
    repeat (2 * CPB) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rx_count == 0, "R1 rx_count", rx_count, 0);
    chk(tx_free == CW'(DEPTH), "R1 tx_free", tx_free, DEPTH);
    chk(!busy, "R1 busy", busy, 0);
    chk(tx_out, "R1 tx_out", tx_out, 1);
    chk(!frame_err && frame_err_cnt == 0, "R1 errors", frame_err_cnt, 0);
  endtask

  task automatic t_single;
    @(negedge clk);
    push_valid = 1; push_data = 8'hA5;
    #1 chk(push_ok, "R2 push accepted", push_ok, 1);
    @(negedge clk);
    push_valid = 0;
    chk(busy, "R8 busy while sending", busy, 1);
    wait_count(1);
    chk(rx_count == 1, "R4 loopback count", rx_count, 1);
    pop_one(8'hA5, "R4 loopback byte");
    chk(rx_count == 0, "R6 pop removes", rx_count, 0);
    repeat (2 * CPB) @(negedge clk);
    chk(!busy, "R8 idle after frame", busy, 0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      push_valid = 1; push_data = 8'(i * 7 + 3);
      #1 chk(push_ok == (i < 17), "R2 accept until full", push_ok, i < 17);
    end
    @(negedge clk);
    push_valid = 0;
    chk(tx_free == 0, "R1 tx full", tx_free, 0);
    msg_len = 0;
    #1 chk(msg_fits, "R3 zero length fits", msg_fits, 1);
    msg_len = 1;
    #1 chk(!msg_fits, "R3 one byte refused", msg_fits, 0);
    wait_count(16);
    repeat (14 * CPB) @(negedge clk);
    chk(rx_count == CW'(DEPTH), "R5 rx stays full", rx_count, DEPTH);
    chk(!busy, "R8 drained", busy, 0);
    for (int i = 0; i < 16; i++) pop_one(i * 7 + 3, "R5 R4 order, overflow dropped");
    @(negedge clk);
    pop_req = 1;
    @(negedge clk);
    pop_req = 0;
    chk(rx_count == 0, "R6 pop on empty", rx_count, 0);
  endtask

  task automatic t_partial_and_clr_tx;
    @(negedge clk);
    push_valid = 1; push_data = 8'h3C; clr_tx = 1;
    #1 chk(!push_ok, "R9 clr_tx beats push", push_ok, 0);
    @(negedge clk);
    push_valid = 0; clr_tx = 0;
    chk(tx_free == CW'(DEPTH) && !busy, "R9 nothing queued", tx_free, DEPTH);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      push_valid = 1; push_data = 8'h51 + 8'(i);
    end
    @(negedge clk);
    push_valid = 0;
    chk(tx_free == CW'(DEPTH - 2), "R1 free after launch", tx_free, DEPTH - 2);
    msg_len = CW'(DEPTH - 2);
    #1 chk(msg_fits, "R3 exact fit", msg_fits, 1);
    msg_len = CW'(DEPTH - 1);
    #1 chk(!msg_fits, "R3 one over", msg_fits, 0);
    clr_tx = 1;
    @(negedge clk);
    clr_tx = 0;
    chk(tx_free == CW'(DEPTH) && busy, "R9 flush keeps frame", tx_free, DEPTH);
    wait_count(1);
    repeat (14 * CPB) @(negedge clk);
    chk(rx_count == 1, "R9 only live frame sent", rx_count, 1);
    pop_one(8'h51, "R9 live byte");
  endtask

  task automatic t_clr_rx;
    @(negedge clk);
    push_valid = 1; push_data = 8'h77;
    @(negedge clk);
    push_data = 8'h78;
    @(negedge clk);
    push_valid = 0;
    wait_count(2);
    chk(rx_count == 2, "R4 two bytes", rx_count, 2);
    clr_rx = 1;
    @(negedge clk);
    clr_rx = 0;
    chk(rx_count == 0, "R9 clr_rx empties", rx_count, 0);
    @(negedge clk);
    push_valid = 1; push_data = 8'h99;
    @(negedge clk);
    push_valid = 0; clr_rx = 1;
    repeat (14 * CPB) @(negedge clk);
    clr_rx = 0;
    @(negedge clk);
    chk(rx_count == 0, "R9 clr_rx beats arrival", rx_count, 0);
  endtask

  task automatic t_frame_err;
    use_loop = 0;
    raw_frame(8'h12, 1'b0);
    chk(frame_err && frame_err_cnt == 1, "R7 first error", frame_err_cnt, 1);
    chk(rx_count == 0, "R7 bad byte dropped", rx_count, 0);
    raw_frame(8'h34, 1'b1);
    chk(frame_err && rx_count == 1, "R7 sticky flag, good byte kept", rx_count, 1);
    pop_one(8'h34, "R4 raw good byte");
    for (int i = 0; i < 16; i++) raw_frame(8'(i), 1'b0);
    chk(frame_err_cnt == '1, "R7 counter saturates", frame_err_cnt, (1 << ERR_W) - 1);
    @(negedge clk);
    clr_err = 1;
    @(negedge clk);
    chk(!frame_err && frame_err_cnt == 0, "R9 clr_err", frame_err_cnt, 0);
    raw_frame(8'h56, 1'b0);
    clr_err = 0;
    @(negedge clk);
    chk(!frame_err && frame_err_cnt == 0, "R9 clr_err beats error", frame_err_cnt, 0);
    use_loop = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_fill();
    t_partial_and_clr_tx();
    t_clr_rx();
    t_frame_err();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule